// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps the frame statistics of an Ethernet MAC. The transmit and receive paths each present a one-cycle event strobe per finished frame, together with the frame length and a few already-decoded attributes. From these events the bank maintains the following:

- total and good frame counts;
- broadcast and multicast counts;
- runt, oversize-drop and segmentation-context counts;
- six frame-size bins per direction;
- a 64-bit octet total per direction, kept as a low and a high register.

Software reads the counters through a simple registered read port. Event counters clear when read. An octet pair clears when its high half is read.

Every counter saturates at all ones instead of wrapping. The width of a counter is `CNT_W`, and an octet pair is `2*CNT_W` wide. The frame length input is `LEN_W` bits wide, and `LEN_W` must be at least 11. The good-frame and good-octet registers are mirrors: on each update they take the new value of the matching total.

Top module: `mac_stat_bank`

## Requirements
- R1: Every event counter adds one per qualifying event and holds at all ones (2^CNT_W-1) instead of wrapping.
- R2: Each octet total is a 2*CNT_W-bit value, read as a low half and a high half. An addition whose true sum exceeds all ones leaves the pair at all ones.
- R3: A receive event adds `rx_len + 4` to the receive octet total. A transmit event adds `tx_len` to the transmit octet total.
- R4: Each event with a length of 64 or more increments exactly one size bin of its direction:
  - bin 0 for a length equal to 64;
  - bin 1 for 65..127;
  - bin 2 for 128..255;
  - bin 3 for 256..511;
  - bin 4 for 512..1023;
  - bin 5 for above 1023.

  A length below 64 increments no bin.
- R5: On a transmit event, a destination `tx_da` of all ones increments the transmit broadcast counter. Otherwise, if `tx_da[40]` is set, the transmit multicast counter increments. Bit 40 is the least significant bit of the first byte, and the first byte is `tx_da[47:40]`. On a receive event, `rx_bcast` and `rx_mcast` each increment their own receive counter.
- R6: In the cycle a frame event updates a total, the good-frame count and the good-octet pair of that direction take the total's new value.
- R7: The segmentation-context counter increments on a transmit event with `tx_tso_last` and `tx_tso_cont` both set, and on no other event.
- R8: A receive event with `rx_runt` set increments the runt counter. An `rx_ovr_drop` strobe increments only the oversize-drop counter.
- R9: A read with `rd_en` returns the addressed register on `rd_data` one cycle later. The addresses are:

  | Address | Register |
  |---|---|
  | 0 | receive total |
  | 1 | transmit total |
  | 2 | receive broadcast |
  | 3 | receive multicast |
  | 4 | transmit broadcast |
  | 5 | transmit multicast |
  | 6 | runt |
  | 7 | oversize drop |
  | 8 | segmentation context |
  | 9..14 | receive bins 0..5 |
  | 15..20 | transmit bins 0..5 |
  | 21 | receive good |
  | 22 | transmit good |
  | 23/24 | receive octets low/high |
  | 25/26 | transmit octets low/high |
  | 27/28 | receive good octets low/high |
  | 29/30 | transmit good octets low/high |

  Reading address 0..22 clears that register. Reading a low half clears nothing. Reading a high half clears both halves of its pair.
- R10: When a read and a frame event hit the same register in one cycle, the read returns the old value, and the register then holds only that event's contribution.
- R11: After reset every register reads zero, and address 31 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_evt | input | 1 | Transmit frame done strobe |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_da | input | 48 | Transmit destination address, first byte in [47:40] |
| tx_tso_last | input | 1 | Frame is the final segment of a segmentation run |
| tx_tso_cont | input | 1 | Frame is not the first segment of its run |
| rx_evt | input | 1 | Receive frame accepted strobe |
| rx_len | input | LEN_W | Receive frame length without FCS |
| rx_bcast | input | 1 | Accepted frame was broadcast |
| rx_mcast | input | 1 | Accepted frame was multicast |
| rx_runt | input | 1 | Accepted frame was below minimum size |
| rx_ovr_drop | input | 1 | Oversize frame dropped |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Read address |
| rd_data | output | CNT_W | Read data, valid the cycle after rd_en |

## Verification
The collision of interest is a software read landing in the same cycle as a frame event that updates the register being read. The bench provokes it in two ways:

- a read of the transmit total while a transmit frame arrives;
- a read of the transmit octet high half while a frame adds to that pair.

It judges the outcome by two checks. The returned data must be the pre-event value. A follow-up read must show only the new frame's count or length. Sweeps over every size-bin boundary and address types, plus runs driven into saturation in a narrow 8-bit configuration, cover the remaining behaviour arithmetically.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int ADDR_W   = 5;
  localparam int NUM_BINS = 6;
  localparam int NUM_EVT  = 21;

  localparam int IX_RX_TOT  = 0;
  localparam int IX_TX_TOT  = 1;
  localparam int IX_RX_BC   = 2;
  localparam int IX_RX_MC   = 3;
  localparam int IX_TX_BC   = 4;
  localparam int IX_TX_MC   = 5;
  localparam int IX_RUNT    = 6;
  localparam int IX_OVR     = 7;
  localparam int IX_TSO     = 8;
  localparam int IX_RX_BIN0 = 9;
  localparam int IX_TX_BIN0 = IX_RX_BIN0 + NUM_BINS;
  localparam int IX_RX_GOOD = NUM_EVT;
  localparam int IX_TX_GOOD = NUM_EVT + 1;
  localparam int IX_RXO_LO  = NUM_EVT + 2;
  localparam int IX_RXO_HI  = NUM_EVT + 3;
  localparam int IX_TXO_LO  = NUM_EVT + 4;
  localparam int IX_TXO_HI  = NUM_EVT + 5;
  localparam int IX_RXG_LO  = NUM_EVT + 6;
  localparam int IX_RXG_HI  = NUM_EVT + 7;
  localparam int IX_TXG_LO  = NUM_EVT + 8;
  localparam int IX_TXG_HI  = NUM_EVT + 9;
endpackage

// File: rtl/mac_stat_bin.sv
module mac_stat_bin
  import mac_stat_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0]    len_i,
  output logic [NUM_BINS-1:0] hit_o
);
  always_comb begin
    hit_o = '0;
    if (len_i > LEN_W'(1023))      hit_o[5] = 1'b1;
    else if (len_i > LEN_W'(511))  hit_o[4] = 1'b1;
    else if (len_i > LEN_W'(255))  hit_o[3] = 1'b1;
    else if (len_i > LEN_W'(127))  hit_o[2] = 1'b1;
    else if (len_i > LEN_W'(64))   hit_o[1] = 1'b1;
    else if (len_i == LEN_W'(64))  hit_o[0] = 1'b1;
  end
endmodule

// File: rtl/mac_stat_sat.sv
module mac_stat_sat #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, base, cnt_d;
  logic             cnt_en;

  always_comb begin
    base   = clr_i ? '0 : cnt_q;
    cnt_d  = base;
    if (inc_i && (base != {CNT_W{1'b1}})) cnt_d = base + 1'b1;
    cnt_en = inc_i | clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mac_stat_total.sv
module mac_stat_total #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic             mclr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mir_o
);
  logic [CNT_W-1:0] cnt_q, mir_q, base, cnt_d, mir_d;
  logic             cnt_en, mir_en;

  always_comb begin
    base   = clr_i ? '0 : cnt_q;
    cnt_d  = base;
    if (inc_i && (base != {CNT_W{1'b1}})) cnt_d = base + 1'b1;
    cnt_en = inc_i | clr_i;
    mir_d  = inc_i ? cnt_d : '0;
    mir_en = inc_i | mclr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mir_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (mir_en) mir_q <= mir_d;
    end
  end

  assign cnt_o = cnt_q;
  assign mir_o = mir_q;
endmodule

// File: rtl/mac_stat_oct.sv
module mac_stat_oct #(
  parameter int CNT_W = 32,
  parameter int ADD_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               add_en_i,
  input  logic [ADD_W-1:0]   add_i,
  input  logic               clr_i,
  input  logic               mclr_i,
  output logic [2*CNT_W-1:0] sum_o,
  output logic [2*CNT_W-1:0] mir_o
);
  localparam int SW = 2 * CNT_W;

  logic [SW-1:0] sum_q, mir_q, base, sum_d, mir_d;
  logic [SW:0]   wide, add_ext;
  logic          sum_en, mir_en;

  always_comb begin
    add_ext = {{(SW + 1 - ADD_W){1'b0}}, add_i};
    base    = clr_i ? '0 : sum_q;
    wide    = {1'b0, base} + add_ext;
    sum_d   = base;
    if (add_en_i) sum_d = wide[SW] ? {SW{1'b1}} : wide[SW-1:0];
    sum_en  = add_en_i | clr_i;
    mir_d   = add_en_i ? sum_d : '0;
    mir_en  = add_en_i | mclr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      mir_q <= '0;
    end else begin
      if (sum_en) sum_q <= sum_d;
      if (mir_en) mir_q <= mir_d;
    end
  end

  assign sum_o = sum_q;
  assign mir_o = mir_q;
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_evt,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [47:0]       tx_da,
  input  logic              tx_tso_last,
  input  logic              tx_tso_cont,
  input  logic              rx_evt,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_bcast,
  input  logic              rx_mcast,
  input  logic              rx_runt,
  input  logic              rx_ovr_drop,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int ADD_W = LEN_W + 1;
  localparam int SW    = 2 * CNT_W;

  logic                rst_meta, rst_n_int;
  logic [NUM_BINS-1:0] rx_hit, tx_hit;
  logic [NUM_EVT-1:0]  inc, clr;
  logic [CNT_W-1:0]    cnt  [NUM_EVT];
  logic [CNT_W-1:0]    good [2];
  logic                tx_bc, tx_mc;
  logic [ADD_W-1:0]    rx_add, tx_add;
  logic [SW-1:0]       rxo, txo, rxg, txg;
  logic [CNT_W-1:0]    rd_val;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_int, rst_meta} <= 2'b00;
    else        {rst_n_int, rst_meta} <= {rst_meta, 1'b1};
  end

  mac_stat_bin #(.LEN_W(LEN_W)) u_rx_bin (.len_i(rx_len), .hit_o(rx_hit));
  mac_stat_bin #(.LEN_W(LEN_W)) u_tx_bin (.len_i(tx_len), .hit_o(tx_hit));

  assign tx_bc = &tx_da;
  assign tx_mc = !tx_bc && tx_da[40];

  always_comb begin
    inc                           = '0;
    inc[IX_RX_TOT]                = rx_evt;
    inc[IX_TX_TOT]                = tx_evt;
    inc[IX_RX_BC]                 = rx_evt & rx_bcast;
    inc[IX_RX_MC]                 = rx_evt & rx_mcast;
    inc[IX_TX_BC]                 = tx_evt & tx_bc;
    inc[IX_TX_MC]                 = tx_evt & tx_mc;
    inc[IX_RUNT]                  = rx_evt & rx_runt;
    inc[IX_OVR]                   = rx_ovr_drop;
    inc[IX_TSO]                   = tx_evt & tx_tso_last & tx_tso_cont;
    inc[IX_RX_BIN0 +: NUM_BINS]   = rx_evt ? rx_hit : '0;
    inc[IX_TX_BIN0 +: NUM_BINS]   = tx_evt ? tx_hit : '0;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign clr[i] = rd_en && (rd_addr == ADDR_W'(i));
    if (i == IX_RX_TOT || i == IX_TX_TOT) begin : g_tot
      mac_stat_total #(.CNT_W(CNT_W)) u_tot (
        .clk    (clk),
        .rst_n  (rst_n_int),
        .inc_i  (inc[i]),
        .clr_i  (clr[i]),
        .mclr_i (rd_en && (rd_addr == ADDR_W'(IX_RX_GOOD + i))),
        .cnt_o  (cnt[i]),
        .mir_o  (good[i])
      );
    end else begin : g_plain
      mac_stat_sat #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n_int),
        .inc_i (inc[i]),
        .clr_i (clr[i]),
        .cnt_o (cnt[i])
      );
    end
  end

  assign rx_add = {1'b0, rx_len} + ADD_W'(4);
  assign tx_add = {1'b0, tx_len};

  mac_stat_oct #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_rx_oct (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .add_en_i (rx_evt),
    .add_i    (rx_add),
    .clr_i    (rd_en && (rd_addr == ADDR_W'(IX_RXO_HI))),
    .mclr_i   (rd_en && (rd_addr == ADDR_W'(IX_RXG_HI))),
    .sum_o    (rxo),
    .mir_o    (rxg)
  );

  mac_stat_oct #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_tx_oct (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .add_en_i (tx_evt),
    .add_i    (tx_add),
    .clr_i    (rd_en && (rd_addr == ADDR_W'(IX_TXO_HI))),
    .mclr_i   (rd_en && (rd_addr == ADDR_W'(IX_TXG_HI))),
    .sum_o    (txo),
    .mir_o    (txg)
  );

  always_comb begin
    rd_val = '0;
    if (int'(rd_addr) < NUM_EVT) begin
      rd_val = cnt[rd_addr];
    end else begin
      case (int'(rd_addr))
        IX_RX_GOOD: rd_val = good[0];
        IX_TX_GOOD: rd_val = good[1];
        IX_RXO_LO:  rd_val = rxo[CNT_W-1:0];
        IX_RXO_HI:  rd_val = rxo[SW-1:CNT_W];
        IX_TXO_LO:  rd_val = txo[CNT_W-1:0];
        IX_TXO_HI:  rd_val = txo[SW-1:CNT_W];
        IX_RXG_LO:  rd_val = rxg[CNT_W-1:0];
        IX_RXG_HI:  rd_val = rxg[SW-1:CNT_W];
        IX_TXG_LO:  rd_val = txg[CNT_W-1:0];
        IX_TXG_HI:  rd_val = txg[SW-1:CNT_W];
        default:    rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  rd_data <= '0;
    else if (rd_en)  rd_data <= rd_val;
  end
endmodule

// File: rtl/mac_stat_bank_chk.sv
module mac_stat_bank_chk
  import mac_stat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_evt,
  input logic               tx_evt,
  input logic               tx_tso_last,
  input logic               tx_tso_cont,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [CNT_W-1:0]   rx_tot,
  input logic [CNT_W-1:0]   tx_tot,
  input logic [CNT_W-1:0]   rx_good,
  input logic [CNT_W-1:0]   tso_cnt,
  input logic [NUM_BINS-1:0] rx_bin_inc,
  input logic [2*CNT_W-1:0] rx_oct
);
  logic rd_tx_tot, rd_rxo_hi, rd_tso;
  assign rd_tx_tot = rd_en && (rd_addr == ADDR_W'(IX_TX_TOT));
  assign rd_rxo_hi = rd_en && (rd_addr == ADDR_W'(IX_RXO_HI));
  assign rd_tso    = rd_en && (rd_addr == ADDR_W'(IX_TSO));

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tot == {CNT_W{1'b1}} && !rd_tx_tot) |=> (tx_tot == {CNT_W{1'b1}})); // R1

  AST_OCT_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rxo_hi |=> (rx_oct >= $past(rx_oct))); // R2

  AST_BIN_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_bin_inc)); // R4

  AST_GOOD_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> (rx_good == rx_tot)); // R6

  AST_TSO_ONLY_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tx_evt && tx_tso_last && tx_tso_cont) && !rd_tso) |=> $stable(tso_cnt)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tx_tot && !tx_evt) |=> (tx_tot == '0)); // R9
endmodule

bind mac_stat_bank mac_stat_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .rx_evt      (rx_evt),
  .tx_evt      (tx_evt),
  .tx_tso_last (tx_tso_last),
  .tx_tso_cont (tx_tso_cont),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .rx_tot      (cnt[mac_stat_pkg::IX_RX_TOT]),
  .tx_tot      (cnt[mac_stat_pkg::IX_TX_TOT]),
  .rx_good     (good[0]),
  .tso_cnt     (cnt[mac_stat_pkg::IX_TSO]),
  .rx_bin_inc  (inc[mac_stat_pkg::IX_RX_BIN0 +: mac_stat_pkg::NUM_BINS]),
  .rx_oct      (rxo)
);

// File: tb/mac_stat_bank_bench.sv
`timescale 1ns/1ps
module mac_stat_bank_bench;
  localparam int CNT_W = 8;
  localparam int LEN_W = 11;
  localparam int CMAX  = 255;
  localparam longint OMAX = 65535;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tx_evt = 1'b0, tx_tso_last = 1'b0, tx_tso_cont = 1'b0;
  logic [LEN_W-1:0] tx_len = '0;
  logic [47:0]      tx_da = '0;
  logic             rx_evt = 1'b0, rx_bcast = 1'b0, rx_mcast = 1'b0;
  logic             rx_runt = 1'b0, rx_ovr_drop = 1'b0;
  logic [LEN_W-1:0] rx_len = '0;
  logic             rd_en = 1'b0;
  logic [4:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;

  int nchk = 0;
  int nfail = 0;

  int     ev [21];
  int     gd [2];
  longint oc [2];
  longint og [2];

  localparam logic [47:0] DA_BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] DA_MC = 48'h0100_5E00_0001;
  localparam logic [47:0] DA_UC = 48'h0211_2233_4455;

  always #2 clk = ~clk;

  mac_stat_bank #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_mac_stat_bank (
    .clk(clk), .rst_n(rst_n),
    .tx_evt(tx_evt), .tx_len(tx_len), .tx_da(tx_da),
    .tx_tso_last(tx_tso_last), .tx_tso_cont(tx_tso_cont),
    .rx_evt(rx_evt), .rx_len(rx_len), .rx_bcast(rx_bcast), .rx_mcast(rx_mcast),
    .rx_runt(rx_runt), .rx_ovr_drop(rx_ovr_drop),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int bin_of(int len);
    if (len > 1023) return 5;
    if (len > 511)  return 4;
    if (len > 255)  return 3;
    if (len > 127)  return 2;
    if (len > 64)   return 1;
    if (len == 64)  return 0;
    return -1;
  endfunction

  function automatic longint osat(longint x);
    return (x > OMAX) ? OMAX : x;
  endfunction

  task automatic m_inc(input int i);
    if (ev[i] < CMAX) ev[i]++;
  endtask

  task automatic m_tx(input int len, input logic [47:0] da, input logic last, input logic cont);
    int b;
    m_inc(1);
    b = bin_of(len);
    if (b >= 0) m_inc(15 + b);
    if (da == DA_BC) m_inc(4);
    else if (da[40]) m_inc(5);
    if (last && cont) m_inc(8);
    oc[1] = osat(oc[1] + len);
    gd[1] = ev[1];
    og[1] = oc[1];
  endtask

  task automatic m_rx(input int len, input logic bc, input logic mc, input logic runt);
    int b;
    m_inc(0);
    b = bin_of(len);
    if (b >= 0) m_inc(9 + b);
    if (bc) m_inc(2);
    if (mc) m_inc(3);
    if (runt) m_inc(6);
    oc[0] = osat(oc[0] + len + 4);
    gd[0] = ev[0];
    og[0] = oc[0];
  endtask

  function automatic int m_read(input int a);
    int v;
    v = 0;
    if (a < 21) begin v = ev[a]; ev[a] = 0; end
    else case (a)
      21: begin v = gd[0]; gd[0] = 0; end
      22: begin v = gd[1]; gd[1] = 0; end
      23: v = int'(oc[0] & 255);
      24: begin v = int'(oc[0] >> 8); oc[0] = 0; end
      25: v = int'(oc[1] & 255);
      26: begin v = int'(oc[1] >> 8); oc[1] = 0; end
      27: v = int'(og[0] & 255);
      28: begin v = int'(og[0] >> 8); og[0] = 0; end
      29: v = int'(og[1] & 255);
      30: begin v = int'(og[1] >> 8); og[1] = 0; end
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input int a, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s addr %0d: got %0d expected %0d", tag, a, act, exp);
    end
  endtask

  task automatic tx_frame(input int len, input logic [47:0] da, input logic last, input logic cont);
    tx_evt = 1'b1; tx_len = LEN_W'(len); tx_da = da;
    tx_tso_last = last; tx_tso_cont = cont;
    @(negedge clk);
    tx_evt = 1'b0; tx_tso_last = 1'b0; tx_tso_cont = 1'b0;
    m_tx(len, da, last, cont);
  endtask

  task automatic rx_frame(input int len, input logic bc, input logic mc, input logic runt);
    rx_evt = 1'b1; rx_len = LEN_W'(len);
    rx_bcast = bc; rx_mcast = mc; rx_runt = runt;
    @(negedge clk);
    rx_evt = 1'b0; rx_bcast = 1'b0; rx_mcast = 1'b0; rx_runt = 1'b0;
    m_rx(len, bc, mc, runt);
  endtask

  task automatic check_rd(input int a, input string tag);
    int e;
    rd_en = 1'b1; rd_addr = 5'(a);
    @(negedge clk);
    rd_en = 1'b0;
    e = m_read(a);
    check(tag, a, int'(rd_data), e);
  endtask

  task automatic dump_all(input string tag);
    for (int a = 0; a < 32; a++) check_rd(a, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired, run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int lens [13] = '{0, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047};
    int e;
    for (int i = 0; i < 21; i++) ev[i] = 0;
    gd[0] = 0; gd[1] = 0; oc[0] = 0; oc[1] = 0; og[0] = 0; og[1] = 0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: everything zero after reset, address 31 zero
    dump_all("R11 reset state");

    // R4 R5 R7 R3: transmit sweep over every bin boundary and address type
    for (int k = 0; k < 13; k++) begin
      tx_frame(lens[k], DA_BC, (k % 3) == 0, (k % 2) == 1);
      tx_frame(lens[k], DA_MC, (k % 2) == 0, 1'b1);
      tx_frame(lens[k], DA_UC, 1'b1, (k % 3) == 1);
    end
    dump_all("R4 R5 R7 R3 R6 tx sweep");

    // R3 R4 R5 R8: receive sweep with flags, oversize drops in between
    for (int k = 0; k < 13; k++) begin
      rx_frame(lens[k], (k % 3) == 0, (k % 3) == 1, lens[k] < 64);
      if (k % 4 == 0) begin
        rx_ovr_drop = 1'b1; @(negedge clk); rx_ovr_drop = 1'b0; m_inc(7);
      end
    end
    dump_all("R3 R4 R5 R8 R6 rx sweep");

    // R9: low half read keeps the pair, high half read clears it
    tx_frame(100, DA_UC, 1'b0, 1'b0);
    check_rd(25, "R9 low read no clear");
    check_rd(25, "R9 low read repeated");
    check_rd(26, "R9 high read");
    check_rd(25, "R9 low after high read");

    // R7: only last and continued together count
    tx_frame(70, DA_UC, 1'b1, 1'b0);
    tx_frame(70, DA_UC, 1'b0, 1'b1);
    tx_frame(70, DA_UC, 1'b1, 1'b1);
    check_rd(8, "R7 segmentation context");
    dump_all("R7 R6 flush");

    // R1: event counters saturate
    for (int k = 0; k < 300; k++) tx_frame(64, DA_BC, 1'b0, 1'b0);
    check_rd(1,  "R1 total saturates");
    check_rd(15, "R1 bin saturates");
    check_rd(4,  "R1 broadcast saturates");
    check_rd(22, "R1 R6 good saturates");
    dump_all("R1 flush");

    // R2: octet pair saturates at all ones
    for (int k = 0; k < 40; k++) rx_frame(2047, 1'b0, 1'b0, 1'b0);
    check_rd(23, "R2 octet low saturated");
    check_rd(24, "R2 octet high saturated");
    check_rd(27, "R2 R6 good octet low");
    check_rd(28, "R2 R6 good octet high");
    dump_all("R2 flush");

    // R10: read and event on the same counter in one cycle
    tx_frame(80, DA_UC, 1'b0, 1'b0);
    tx_frame(80, DA_UC, 1'b0, 1'b0);
    rd_en = 1'b1; rd_addr = 5'd1;
    tx_evt = 1'b1; tx_len = LEN_W'(300); tx_da = DA_UC;
    @(negedge clk);
    rd_en = 1'b0; tx_evt = 1'b0;
    e = m_read(1);
    m_tx(300, DA_UC, 1'b0, 1'b0);
    check("R10 read returns old count", 1, int'(rd_data), e);
    check_rd(1, "R10 count holds new event only");

    // R10: high octet read with an addition in the same cycle
    rd_en = 1'b1; rd_addr = 5'd26;
    tx_evt = 1'b1; tx_len = LEN_W'(700); tx_da = DA_MC;
    @(negedge clk);
    rd_en = 1'b0; tx_evt = 1'b0;
    e = m_read(26);
    m_tx(700, DA_MC, 1'b0, 1'b0);
    check("R10 octet read returns old high", 26, int'(rd_data), e);
    check_rd(25, "R10 octet low holds new length");
    check_rd(26, "R10 octet high holds new length");
    dump_all("R10 R11 final");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule